// File: doc/BRIEF.md
# Clipped Solid Rectangle Fill Engine

This block paints an axis-aligned rectangle of a linear framebuffer with a single color. Software first loads a color and an origin point through a small register write port. It then writes the rectangle size, and that write starts the fill. A separately programmed clip window limits which pixels of the rectangle are actually written. Only the intersection of the two rectangles reaches memory.

The engine walks the intersection one row at a time, from top to bottom and from left to right. It emits one pixel write per clock cycle on a plain memory write port. Each address is formed from a fixed base, a fixed row pitch and a fixed pixel size. A busy output reports activity. While the engine is busy, the register port deasserts its ready output, and any write offered during that time is not taken.

Top module: `rfill_engine`

## Requirements
- R1: After reset, `busy` is low, `cfg_ready` is high and `mem_we` is low.
- R2: The register select codes are: 0 = color, 1 = origin, 2 = size, 3 = clip origin, 4 = clip size. Each point or extent word carries X (or width) in bits 15:0 and Y (or height) in bits 31:16.
- R3: Writes to color, origin or clip registers issue no memory writes. A write to the size register starts a fill that uses the color and origin already held.
- R4: A pixel is written if and only if it lies inside both the fill rectangle and the clip window. The clip window is half-open: it covers origin to origin + extent - 1 on each axis.
- R5: If the fill rectangle and the clip window do not overlap, including when they only touch at an edge, no memory write is issued and `busy` is high for exactly one cycle.
- R6: A width or height of zero issues no memory writes and is high on `busy` for exactly one cycle.
- R7: A pixel's address is BASE_ADDR + y*PITCH_BYTES + x*PIXEL_BYTES. Pixels are issued left to right within a row, and rows are issued top to bottom.
- R8: `busy` rises in the cycle after the size write. Pixels then follow on consecutive cycles, one per cycle. `busy` stays high for exactly (pixel count + 1) cycles.
- R9: `cfg_ready` is low whenever `busy` is high. A register write offered while `cfg_ready` is low changes nothing.
- R10: Writes with select codes 5, 6 or 7 change no register.
- R11: `mem_wdata` equals the latched fill color on every pixel write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select code |
| cfg_wdata | input | 32 | Register write data |
| cfg_ready | output | 1 | High when a register write is taken |
| busy | output | 1 | High while a fill is in progress |
| mem_we | output | 1 | Pixel write strobe |
| mem_addr | output | ADDR_W | Pixel byte address |
| mem_wdata | output | COLOR_W | Pixel color |

## Verification
The hardest condition to reach is a register write that arrives while a fill is running. Normal traffic waits for `cfg_ready`, so it never produces this case. The bench therefore starts a multi-row fill and, in the middle of it, forces a single-cycle color write that ignores ready. It then launches a second fill with only a size write and checks that the old color still appears on the memory port. Clip windows that touch the fill rectangle exactly at an edge exercise the half-open bounds, and partial overlaps exercise each of the four clip edges.

// File: rtl/rfill_pkg.sv
package rfill_pkg;

  typedef logic [15:0] coord_t;
  typedef logic [16:0] ext_t;

  // One 32-bit point/extent word: lo = X or width, hi = Y or height
  typedef struct packed {
    coord_t hi;
    coord_t lo;
  } pair_t;

  typedef enum logic [2:0] {
    SEL_COLOR     = 3'd0,
    SEL_ORIGIN    = 3'd1,
    SEL_SIZE      = 3'd2,
    SEL_CLIP_ORG  = 3'd3,
    SEL_CLIP_SIZE = 3'd4
  } cfg_sel_e;

  typedef enum logic {
    WALK_IDLE = 1'b0,
    WALK_RUN  = 1'b1
  } walk_state_e;

endpackage

// File: rtl/rfill_regs.sv
module rfill_regs
  import rfill_pkg::*;
#(
  parameter int COLOR_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [2:0]         sel,
  input  logic [31:0]        wdata,
  input  logic               ready,
  output logic [COLOR_W-1:0] color,
  output pair_t              fill_org,
  output pair_t              fill_ext,
  output pair_t              clip_org,
  output pair_t              clip_ext,
  output logic               start
);

  logic take;
  logic en_color, en_org, en_ext, en_corg, en_cext;
  logic start_d;

  always_comb begin
    take     = we && ready;
    en_color = take && (cfg_sel_e'(sel) == SEL_COLOR);
    en_org   = take && (cfg_sel_e'(sel) == SEL_ORIGIN);
    en_ext   = take && (cfg_sel_e'(sel) == SEL_SIZE);
    en_corg  = take && (cfg_sel_e'(sel) == SEL_CLIP_ORG);
    en_cext  = take && (cfg_sel_e'(sel) == SEL_CLIP_SIZE);
    start_d  = en_ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      color    <= '0;
      fill_org <= '0;
      fill_ext <= '0;
      clip_org <= '0;
      clip_ext <= '0;
      start    <= 1'b0;
    end else begin
      if (en_color) color    <= wdata[COLOR_W-1:0];
      if (en_org)   fill_org <= pair_t'(wdata);
      if (en_ext)   fill_ext <= pair_t'(wdata);
      if (en_corg)  clip_org <= pair_t'(wdata);
      if (en_cext)  clip_ext <= pair_t'(wdata);
      start <= start_d;
    end
  end

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> ($stable(color) && $stable(fill_org) && $stable(clip_org) && $stable(clip_ext)));

  // R3
  start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we && ready && (sel == 3'd2) |=> start);

  // R10
  bad_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we && (sel > 3'd4) |=> ($stable(color) && $stable(fill_org) && $stable(fill_ext)
                            && $stable(clip_org) && $stable(clip_ext)));

endmodule

// File: rtl/rfill_clip.sv
module rfill_clip
  import rfill_pkg::*;
(
  input  pair_t fill_org,
  input  pair_t fill_ext,
  input  pair_t clip_org,
  input  pair_t clip_ext,
  output ext_t  lo_x,
  output ext_t  hi_x,
  output ext_t  lo_y,
  output ext_t  hi_y,
  output logic  empty
);

  coord_t f_org [2];
  coord_t f_ext [2];
  coord_t c_org [2];
  coord_t c_ext [2];
  ext_t   lo    [2];
  ext_t   hi    [2];
  logic   none  [2];

  always_comb begin
    f_org[0] = fill_org.lo; f_org[1] = fill_org.hi;
    f_ext[0] = fill_ext.lo; f_ext[1] = fill_ext.hi;
    c_org[0] = clip_org.lo; c_org[1] = clip_org.hi;
    c_ext[0] = clip_ext.lo; c_ext[1] = clip_ext.hi;
  end

  // Same half-open interval intersection on each axis
  for (genvar ax = 0; ax < 2; ax++) begin : g_axis
    ext_t f_end, c_end, f_beg, c_beg;
    always_comb begin
      f_beg    = {1'b0, f_org[ax]};
      c_beg    = {1'b0, c_org[ax]};
      f_end    = f_beg + {1'b0, f_ext[ax]};
      c_end    = c_beg + {1'b0, c_ext[ax]};
      lo[ax]   = (f_beg > c_beg) ? f_beg : c_beg;
      hi[ax]   = (f_end < c_end) ? f_end : c_end;
      none[ax] = (lo[ax] >= hi[ax]);
    end
  end

  always_comb begin
    lo_x  = lo[0];
    hi_x  = hi[0];
    lo_y  = lo[1];
    hi_y  = hi[1];
    empty = none[0] || none[1];
  end

endmodule

// File: rtl/rfill_walk.sv
module rfill_walk
  import rfill_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   empty,
  input  ext_t   lo_x,
  input  ext_t   hi_x,
  input  ext_t   lo_y,
  input  ext_t   hi_y,
  output logic   run,
  output coord_t cur_x,
  output coord_t cur_y
);

  walk_state_e state_q, state_d;
  coord_t      x_d, y_d;
  logic        row_end, last_row;

  always_comb begin
    row_end  = ({1'b0, cur_x} + 17'd1) == hi_x;
    last_row = ({1'b0, cur_y} + 17'd1) == hi_y;
    state_d  = state_q;
    x_d      = cur_x;
    y_d      = cur_y;
    unique case (state_q)
      WALK_IDLE: begin
        if (start && !empty) begin
          state_d = WALK_RUN;
          x_d     = coord_t'(lo_x);
          y_d     = coord_t'(lo_y);
        end
      end
      WALK_RUN: begin
        if (row_end) begin
          x_d = coord_t'(lo_x);
          if (last_row) state_d = WALK_IDLE;
          else          y_d = cur_y + 16'd1;
        end else begin
          x_d = cur_x + 16'd1;
        end
      end
      default: state_d = WALK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WALK_IDLE;
      cur_x   <= '0;
      cur_y   <= '0;
    end else begin
      state_q <= state_d;
      cur_x   <= x_d;
      cur_y   <= y_d;
    end
  end

  assign run = (state_q == WALK_RUN);

  // R4
  in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> ({1'b0, cur_x} >= lo_x && {1'b0, cur_x} < hi_x &&
             {1'b0, cur_y} >= lo_y && {1'b0, cur_y} < hi_y));

  // R7
  x_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && $past(run) && (cur_y == $past(cur_y)) |-> cur_x == $past(cur_x) + 16'd1);

  // R5
  empty_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && empty && !run |=> !run);

endmodule

// File: rtl/rfill_engine.sv
module rfill_engine
  import rfill_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int COLOR_W     = 32,
  parameter int PITCH_BYTES = 2048,
  parameter int PIXEL_BYTES = 4,
  parameter int BASE_ADDR   = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [2:0]         cfg_sel,
  input  logic [31:0]        cfg_wdata,
  output logic               cfg_ready,
  output logic               busy,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [COLOR_W-1:0] mem_wdata
);

  localparam bit PIX_POW2  = (PIXEL_BYTES & (PIXEL_BYTES - 1)) == 0;
  localparam int PIX_SHIFT = $clog2(PIXEL_BYTES);

  logic [COLOR_W-1:0] color;
  pair_t  fill_org, fill_ext, clip_org, clip_ext;
  logic   start, empty, run;
  ext_t   lo_x, hi_x, lo_y, hi_y;
  coord_t cur_x, cur_y;
  logic [ADDR_W-1:0] row_off, col_off;

  rfill_regs #(.COLOR_W(COLOR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .sel      (cfg_sel),
    .wdata    (cfg_wdata),
    .ready    (cfg_ready),
    .color    (color),
    .fill_org (fill_org),
    .fill_ext (fill_ext),
    .clip_org (clip_org),
    .clip_ext (clip_ext),
    .start    (start)
  );

  rfill_clip u_clip (
    .fill_org (fill_org),
    .fill_ext (fill_ext),
    .clip_org (clip_org),
    .clip_ext (clip_ext),
    .lo_x     (lo_x),
    .hi_x     (hi_x),
    .lo_y     (lo_y),
    .hi_y     (hi_y),
    .empty    (empty)
  );

  rfill_walk u_walk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .empty (empty),
    .lo_x  (lo_x),
    .hi_x  (hi_x),
    .lo_y  (lo_y),
    .hi_y  (hi_y),
    .run   (run),
    .cur_x (cur_x),
    .cur_y (cur_y)
  );

  always_comb row_off = ADDR_W'(cur_y) * ADDR_W'(PITCH_BYTES);

  if (PIX_POW2) begin : g_pix_shift
    always_comb col_off = ADDR_W'(cur_x) << PIX_SHIFT;
  end else begin : g_pix_mul
    always_comb col_off = ADDR_W'(cur_x) * ADDR_W'(PIXEL_BYTES);
  end

  always_comb begin
    busy      = start || run;
    cfg_ready = !busy;
    mem_we    = run;
    mem_addr  = ADDR_W'(BASE_ADDR) + row_off + col_off;
    mem_wdata = color;
  end

  // R9
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !cfg_ready);

  // R8
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_ready && (cfg_sel == 3'd2) |=> busy);

endmodule

// File: tb/rfill_engine_test.sv
module rfill_engine_test;

  localparam int CLK_PERIOD = 10;
  localparam int PITCH      = 2048;
  localparam int PIX        = 4;
  localparam int CAP_N      = 1024;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic        cfg_ready;
  logic        busy;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;

  int n_chk  = 0;
  int n_fail = 0;

  int          cap_cnt  = 0;
  int          busy_cnt = 0;
  logic [31:0] cap_addr [CAP_N];
  logic [31:0] cap_data [CAP_N];

  // Bench shadow of programmed values
  int          s_ox, s_oy, s_cx, s_cy, s_cw, s_ch;
  logic [31:0] s_color;

  rfill_engine #(
    .ADDR_W(32), .COLOR_W(32), .PITCH_BYTES(PITCH), .PIXEL_BYTES(PIX), .BASE_ADDR(0)
  ) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .cfg_ready (cfg_ready),
    .busy      (busy),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (mem_we) begin
      cap_addr[cap_cnt % CAP_N] <= mem_addr;
      cap_data[cap_cnt % CAP_N] <= mem_wdata;
      cap_cnt <= cap_cnt + 1;
    end
    if (busy) busy_cnt <= busy_cnt + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic write_reg(input logic [2:0] sel, input logic [31:0] data);
    int guard = 0;
    @(negedge clk);
    while (!cfg_ready && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_color(input logic [31:0] c);
    s_color = c;
    write_reg(3'd0, c);
  endtask

  task automatic set_origin(input int x, input int y);
    s_ox = x; s_oy = y;
    write_reg(3'd1, {y[15:0], x[15:0]});
  endtask

  task automatic set_clip(input int x, input int y, input int w, input int h);
    s_cx = x; s_cy = y; s_cw = w; s_ch = h;
    write_reg(3'd3, {y[15:0], x[15:0]});
    write_reg(3'd4, {h[15:0], w[15:0]});
  endtask

  // Launch with a size write, wait for completion, check writes
  task automatic run_fill(input int w, input int h, input string tag);
    int cap0, busy0, n_exp, k, guard, bad_k;
    logic [31:0] ea, bad_a, bad_d;
    cap0 = cap_cnt; busy0 = busy_cnt;
    write_reg(3'd2, {h[15:0], w[15:0]});
    guard = 0;
    while (busy && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    #1;
    check(guard < 5000, "R8", {tag, " completion"}, guard, 0);
    n_exp = 0;
    bad_k = -1; bad_a = '0; bad_d = '0;
    for (int y = s_oy; y < s_oy + h; y++) begin
      for (int x = s_ox; x < s_ox + w; x++) begin
        if (x >= s_cx && x < s_cx + s_cw && y >= s_cy && y < s_cy + s_ch) begin
          ea = 32'(y * PITCH + x * PIX);
          k = cap0 + n_exp;
          if (bad_k < 0 && k < cap_cnt &&
              (cap_addr[k % CAP_N] != ea || cap_data[k % CAP_N] != s_color)) begin
            bad_k = n_exp; bad_a = ea; bad_d = cap_data[k % CAP_N];
          end
          n_exp++;
        end
      end
    end
    check(cap_cnt - cap0 == n_exp, "R4", {tag, " pixel count"}, cap_cnt - cap0, n_exp);
    if (bad_k >= 0) begin
      check(1'b0, "R7", {tag, " address/order at index"}, cap_addr[(cap0 + bad_k) % CAP_N], bad_a);
      check(bad_d == s_color, "R11", {tag, " color"}, bad_d, s_color);
    end else begin
      check(1'b1, "R7", {tag, " address/order"}, 0, 0);
    end
    check(busy_cnt - busy0 == n_exp + 1, "R8", {tag, " busy cycles"},
          busy_cnt - busy0, n_exp + 1);
  endtask

  task automatic t_reset;
    check(busy == 1'b0, "R1", "busy after reset", busy, 0);
    check(cfg_ready == 1'b1, "R1", "ready after reset", cfg_ready, 1);
    check(mem_we == 1'b0, "R1", "mem_we after reset", mem_we, 0);
  endtask

  task automatic t_basic;
    int c0;
    c0 = cap_cnt;
    set_clip(0, 0, 100, 100);
    set_color(32'hA5A5_0001);
    set_origin(3, 2);
    repeat (3) @(negedge clk);
    check(cap_cnt == c0, "R3", "no writes before size", cap_cnt - c0, 0);
    run_fill(4, 3, "R2 basic");
  endtask

  task automatic t_partial_clip;
    set_clip(8, 7, 4, 20);
    set_color(32'h0000_BEEF);
    set_origin(5, 5);
    run_fill(10, 6, "R4 partial clip");
    set_clip(0, 0, 7, 6);
    run_fill(10, 6, "R4 clip low corner");
  endtask

  task automatic t_disjoint;
    set_clip(10, 10, 5, 5);
    set_origin(0, 0);
    run_fill(4, 4, "R5 disjoint");
    set_clip(0, 0, 10, 10);
    set_origin(10, 0);
    run_fill(2, 2, "R5 edge touch");
    set_origin(0, 10);
    run_fill(2, 2, "R5 edge touch y");
  endtask

  task automatic t_zero;
    set_clip(0, 0, 50, 50);
    set_origin(1, 1);
    run_fill(0, 5, "R6 zero width");
    run_fill(5, 0, "R6 zero height");
  endtask

  task automatic t_held_off;
    logic [31:0] old_c;
    int guard;
    set_clip(0, 0, 64, 64);
    set_color(32'h1234_5678);
    old_c = s_color;
    set_origin(2, 3);
    write_reg(3'd2, {16'd3, 16'd8});
    repeat (3) @(negedge clk);
    check(busy == 1'b1, "R9", "busy mid fill", busy, 1);
    check(cfg_ready == 1'b0, "R9", "ready low while busy", cfg_ready, 0);
    cfg_we = 1'b1; cfg_sel = 3'd0; cfg_wdata = 32'hDEAD_0000;
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'd1; cfg_wdata = 32'h0000_0000;
    @(negedge clk);
    cfg_we = 1'b0;
    guard = 0;
    while (busy && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    s_color = old_c;
    run_fill(8, 3, "R9 refill after ignored writes");
  endtask

  task automatic t_bad_sel;
    set_clip(0, 0, 64, 64);
    set_color(32'h0F0F_0F0F);
    set_origin(4, 4);
    write_reg(3'd5, 32'h0001_0001);
    write_reg(3'd6, 32'hFFFF_FFFF);
    write_reg(3'd7, 32'h0000_0000);
    check(busy == 1'b0, "R10", "no start from bad select", busy, 0);
    run_fill(2, 2, "R10 after bad selects");
  endtask

  initial begin
    cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    s_ox = 0; s_oy = 0; s_cx = 0; s_cy = 0; s_cw = 0; s_ch = 0; s_color = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_basic();
    t_partial_clip();
    t_disjoint();
    t_zero();
    t_held_off();
    t_bad_sel();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule